// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block brings a DDR3 memory subsystem from power-on to a state where normal traffic and periodic refresh may begin. After a `start` pulse it runs the PHY initialization handshake. It then drives the memory reset line, the memory clock enable and CKE through their required intervals. For every chip select in turn it issues a NOP, the four mode-register writes and a long ZQ calibration. It ends with a precharge-all to every chip and raises `done`, after which the surrounding controller can enable auto refresh.

Every interval is a cycle count on an input port, so firmware or strap logic can set it for the memory clock in use. The ZQ calibration wait is a parameter. The sequence has one fixed order: a single down-counter times every wait, and a registered encoder drives the command bus. The bus shows a deselect (all chip selects high) in every cycle that carries no command.

Top module: `ddr3_init_seq`

## Requirements
- R1: One cycle after `start` is seen in the idle state, `phy_init_start` goes high. It stays high while `phy_init_done` is low, and it goes low one cycle after `phy_init_done` is sampled high.
- R2: `mem_reset_n` is low from reset. It rises exactly `t_rst_low` cycles after `phy_init_start` falls, and it never falls again before the next reset. `cke` stays low throughout this time.
- R3: `ck_en` rises in the same cycle as `mem_reset_n`. `cke` rises exactly max(`t_rst_to_cke`, `t_clk_stable`) cycles after that, and `cke` is never high while `mem_reset_n` is low.
- R4: A timing count of zero acts as a count of one. Once loaded, the wait counter drops by exactly one each cycle until it reaches zero.
- R5: The first command, a NOP to rank 0, appears one cycle after `cke` rises. The next command follows exactly `t_xpr` cycles after each NOP.
- R6: The mode-register writes for a rank follow this order and content. MR2 goes on bank 2 with A10 and A9 forced to 0. MR3 goes on bank 3 unchanged. MR1 goes on bank 1 with A0 forced to 0, which enables the DLL. MR0 goes on bank 0 with A8 forced to 1 (DLL reset), and a second MR0 follows on bank 0 with A8 forced to 0. Consecutive writes are `t_mrd` apart, and the ZQ command follows the second MR0 by `t_mod`.
- R7: Command encodings are written {ras_n, cas_n, we_n}: NOP = 111, mode-register write = 000, ZQ long = 110, precharge-all = 010. A per-rank command drives only bit r of `cs_n` low, and bank/address are zero unless stated otherwise.
- R8: ZQ long carries A10 = 1. The next rank's NOP follows it by `ZQINIT_CYCLES`, and the NOP to mode-register to ZQ series repeats for every rank in ascending order.
- R9: Precharge-all drives every `cs_n` bit low, carries A10 = 1 and comes `ZQINIT_CYCLES` after the last ZQ. `done` rises in the same cycle and stays high.
- R10: Outside command cycles the bus shows all `cs_n` high. Exactly 7×RANKS+1 commands are issued, with none after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins the sequence from idle |
| phy_init_done | input | 1 | PHY reports its initialization complete |
| t_rst_low | input | CNT_W | Memory reset low time after PHY handshake, cycles |
| t_rst_to_cke | input | CNT_W | Reset release to CKE high, cycles |
| t_clk_stable | input | CNT_W | Clock running time before CKE high, cycles |
| t_xpr | input | CNT_W | NOP to first mode-register write, cycles |
| t_mrd | input | CNT_W | Mode-register write to mode-register write, cycles |
| t_mod | input | CNT_W | Last mode-register write to ZQ, cycles |
| mr0_val | input | ROW_W | MR0 operating value |
| mr1_val | input | ROW_W | MR1 operating value |
| mr2_val | input | ROW_W | MR2 operating value |
| mr3_val | input | ROW_W | MR3 operating value |
| phy_init_start | output | 1 | Request to the PHY to initialize |
| mem_reset_n | output | 1 | Memory reset, active low |
| ck_en | output | 1 | Enables the memory clock |
| cke | output | 1 | Memory clock enable |
| cs_n | output | RANKS | Chip selects, one per rank |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable |
| bank | output | BANK_W | Bank address |
| addr | output | ROW_W | Address bus |
| done | output | 1 | Initialization complete |

## Verification
The assertions assume that `phy_init_done` rises only while the handshake is open, and that the timing and mode-register inputs do not change during a run. The handshake check in particular relies on the PHY never answering before it is asked. The bench holds every timing and MR value fixed from before `start` until `done`. It raises `phy_init_done` only after it has seen `phy_init_start` high, and it drops `phy_init_done` again once the request falls. Between runs it changes values only while reset is applied, so each run begins from the idle state.

// File: rtl/ddr3i_pkg.sv
package ddr3i_pkg;

  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_MRS  = 2'd1,
    CMD_ZQCL = 2'd2,
    CMD_PREA = 2'd3
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PHY, S_RST, S_CKW, S_NOP, S_MR2, S_MR3,
    S_MR1, S_MR0R, S_MR0, S_ZQ, S_PREA, S_DONE
  } seq_e;

  // {ras_n, cas_n, we_n} for each command kind
  function automatic logic [2:0] strobe_bits(input cmd_e c);
    case (c)
      CMD_NOP:  return 3'b111;
      CMD_MRS:  return 3'b000;
      CMD_ZQCL: return 3'b110;
      default:  return 3'b010;
    endcase
  endfunction

endpackage

// File: rtl/ddr3i_timer.sv
module ddr3i_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R4

endmodule

// File: rtl/ddr3i_cmd_enc.sv
module ddr3i_cmd_enc
  import ddr3i_pkg::*;
#(
  parameter int RANKS  = 2,
  parameter int ROW_W  = 16,
  parameter int BANK_W = 3,
  localparam int RK_W  = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  cmd_e              kind,
  input  logic [RK_W-1:0]   rank,
  input  logic              to_all,
  input  logic [BANK_W-1:0] bank_in,
  input  logic [ROW_W-1:0]  addr_in,
  output logic [RANKS-1:0]  cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  addr
);

  logic [RANKS-1:0] sel_one;
  assign sel_one = RANKS'(1) << rank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n <= '1;
      {ras_n, cas_n, we_n} <= 3'b111;
      bank <= '0;
      addr <= '0;
    end else if (issue) begin
      cs_n <= to_all ? '0 : ~sel_one;
      {ras_n, cas_n, we_n} <= strobe_bits(kind);
      bank <= bank_in;
      addr <= addr_in;
    end else begin
      cs_n <= '1;
      {ras_n, cas_n, we_n} <= 3'b111;
      bank <= '0;
      addr <= '0;
    end
  end

  AST_CS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~cs_n) <= 1) || (cs_n == '0)); // R7

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3i_pkg::*;
#(
  parameter int RANKS         = 2,
  parameter int ROW_W         = 16,
  parameter int BANK_W        = 3,
  parameter int CNT_W         = 20,
  parameter int ZQINIT_CYCLES = 512,
  localparam int RK_W         = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              phy_init_done,
  input  logic [CNT_W-1:0]  t_rst_low,
  input  logic [CNT_W-1:0]  t_rst_to_cke,
  input  logic [CNT_W-1:0]  t_clk_stable,
  input  logic [CNT_W-1:0]  t_xpr,
  input  logic [CNT_W-1:0]  t_mrd,
  input  logic [CNT_W-1:0]  t_mod,
  input  logic [ROW_W-1:0]  mr0_val,
  input  logic [ROW_W-1:0]  mr1_val,
  input  logic [ROW_W-1:0]  mr2_val,
  input  logic [ROW_W-1:0]  mr3_val,
  output logic              phy_init_start,
  output logic              mem_reset_n,
  output logic              ck_en,
  output logic              cke,
  output logic [RANKS-1:0]  cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  addr,
  output logic              done
);

  localparam logic [ROW_W-1:0] BIT_A0  = ROW_W'(1);
  localparam logic [ROW_W-1:0] BIT_A8  = ROW_W'(1) << 8;
  localparam logic [ROW_W-1:0] BIT_A9  = ROW_W'(1) << 9;
  localparam logic [ROW_W-1:0] BIT_A10 = ROW_W'(1) << 10;
  localparam logic [RK_W-1:0]  LAST_RK = RK_W'(RANKS - 1);

  // value to load so that the next action lands n cycles later (0 acts as 1)
  function automatic logic [CNT_W-1:0] wait_load(input logic [CNT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] longer(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  seq_e              state, state_nx;
  logic [RK_W-1:0]   rank;
  logic              rank_step;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val, tmr_cnt;
  logic              cmd_issue, cmd_all, rst_release, cke_raise;
  cmd_e              cmd_kind;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0]  cmd_addr;
  logic              rst_q, cke_q;

  ddr3i_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .cnt(tmr_cnt), .expired(tmr_zero)
  );

  always_comb begin
    state_nx    = state;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    cmd_issue   = 1'b0;
    cmd_kind    = CMD_NOP;
    cmd_all     = 1'b0;
    cmd_bank    = '0;
    cmd_addr    = '0;
    rst_release = 1'b0;
    cke_raise   = 1'b0;
    rank_step   = 1'b0;
    case (state)
      S_IDLE: if (start) state_nx = S_PHY;
      S_PHY: if (phy_init_done) begin
        state_nx = S_RST;
        tmr_load = 1'b1;
        tmr_val  = wait_load(t_rst_low);
      end
      S_RST: if (tmr_zero) begin
        rst_release = 1'b1;
        tmr_load    = 1'b1;
        tmr_val     = wait_load(longer(t_rst_to_cke, t_clk_stable));
        state_nx    = S_CKW;
      end
      S_CKW: if (tmr_zero) begin
        cke_raise = 1'b1;
        state_nx  = S_NOP;
      end
      S_NOP: if (tmr_zero) begin
        cmd_issue = 1'b1;
        tmr_load  = 1'b1;
        tmr_val   = wait_load(t_xpr);
        state_nx  = S_MR2;
      end
      S_MR2: if (tmr_zero) begin
        cmd_issue = 1'b1; cmd_kind = CMD_MRS; cmd_bank = BANK_W'(2);
        cmd_addr  = mr2_val & ~(BIT_A10 | BIT_A9);
        tmr_load  = 1'b1; tmr_val = wait_load(t_mrd);
        state_nx  = S_MR3;
      end
      S_MR3: if (tmr_zero) begin
        cmd_issue = 1'b1; cmd_kind = CMD_MRS; cmd_bank = BANK_W'(3);
        cmd_addr  = mr3_val;
        tmr_load  = 1'b1; tmr_val = wait_load(t_mrd);
        state_nx  = S_MR1;
      end
      S_MR1: if (tmr_zero) begin
        cmd_issue = 1'b1; cmd_kind = CMD_MRS; cmd_bank = BANK_W'(1);
        cmd_addr  = mr1_val & ~BIT_A0;
        tmr_load  = 1'b1; tmr_val = wait_load(t_mrd);
        state_nx  = S_MR0R;
      end
      S_MR0R: if (tmr_zero) begin
        cmd_issue = 1'b1; cmd_kind = CMD_MRS;
        cmd_addr  = mr0_val | BIT_A8;
        tmr_load  = 1'b1; tmr_val = wait_load(t_mrd);
        state_nx  = S_MR0;
      end
      S_MR0: if (tmr_zero) begin
        cmd_issue = 1'b1; cmd_kind = CMD_MRS;
        cmd_addr  = mr0_val & ~BIT_A8;
        tmr_load  = 1'b1; tmr_val = wait_load(t_mod);
        state_nx  = S_ZQ;
      end
      S_ZQ: if (tmr_zero) begin
        cmd_issue = 1'b1; cmd_kind = CMD_ZQCL; cmd_addr = BIT_A10;
        tmr_load  = 1'b1; tmr_val = wait_load(CNT_W'(ZQINIT_CYCLES));
        if (rank == LAST_RK) state_nx = S_PREA;
        else begin
          rank_step = 1'b1;
          state_nx  = S_NOP;
        end
      end
      S_PREA: if (tmr_zero) begin
        cmd_issue = 1'b1; cmd_kind = CMD_PREA; cmd_all = 1'b1;
        cmd_addr  = BIT_A10;
        state_nx  = S_DONE;
      end
      S_DONE:  state_nx = S_DONE;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      rank  <= '0;
      rst_q <= 1'b0;
      cke_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (rank_step)   rank  <= rank + 1'b1;
      if (rst_release) rst_q <= 1'b1;
      if (cke_raise)   cke_q <= 1'b1;
    end
  end

  ddr3i_cmd_enc #(.RANKS(RANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .issue(cmd_issue), .kind(cmd_kind),
    .rank(rank), .to_all(cmd_all), .bank_in(cmd_bank), .addr_in(cmd_addr),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bank(bank), .addr(addr)
  );

  assign phy_init_start = (state == S_PHY);
  assign mem_reset_n    = rst_q;
  assign ck_en          = rst_q;
  assign cke            = cke_q;
  assign done           = (state == S_DONE);

  AST_PHY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_init_start && !phy_init_done) |=> phy_init_start); // R1
  AST_RESET_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_reset_n |=> mem_reset_n); // R2
  AST_CKE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> mem_reset_n); // R3
  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> cke); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && cs_n == '1)); // R9
  AST_ZQ_A10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1 && {ras_n, cas_n, we_n} == 3'b110) |-> addr[10]); // R8

endmodule

// File: tb/ddr3_init_seq_test.sv
module ddr3_init_seq_test;

  localparam int RANKS = 2;
  localparam int ROW_W = 16;
  localparam int BANK_W = 3;
  localparam int CNT_W = 20;
  localparam int ZQ = 512;
  localparam int NEV = 7 * RANKS + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic phy_init_done = 1'b0;
  logic [CNT_W-1:0] t_rst_low = 0, t_rst_to_cke = 0, t_clk_stable = 0;
  logic [CNT_W-1:0] t_xpr = 0, t_mrd = 0, t_mod = 0;
  logic [ROW_W-1:0] mr0_val = 0, mr1_val = 0, mr2_val = 0, mr3_val = 0;
  logic phy_init_start, mem_reset_n, ck_en, cke, ras_n, cas_n, we_n, done;
  logic [RANKS-1:0] cs_n;
  logic [BANK_W-1:0] bank;
  logic [ROW_W-1:0] addr;

  always #10 clk = ~clk;

  ddr3_init_seq #(.RANKS(RANKS), .ROW_W(ROW_W), .BANK_W(BANK_W),
                  .CNT_W(CNT_W), .ZQINIT_CYCLES(ZQ)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .phy_init_done(phy_init_done),
    .t_rst_low(t_rst_low), .t_rst_to_cke(t_rst_to_cke),
    .t_clk_stable(t_clk_stable), .t_xpr(t_xpr), .t_mrd(t_mrd), .t_mod(t_mod),
    .mr0_val(mr0_val), .mr1_val(mr1_val), .mr2_val(mr2_val), .mr3_val(mr3_val),
    .phy_init_start(phy_init_start), .mem_reset_n(mem_reset_n), .ck_en(ck_en),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .bank(bank), .addr(addr), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ev_n = 0;
  int ev_cyc[32];
  logic [RANKS-1:0] ev_cs[32];
  logic [2:0] ev_rcw[32];
  logic [BANK_W-1:0] ev_bank[32];
  logic [ROW_W-1:0] ev_addr[32];
  int start_fall, rst_rise, ck_rise, cke_rise, done_rise;
  int cke_early;
  logic p_start, p_rst, p_ck, p_cke, p_done;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      ev_n = 0; start_fall = -1; rst_rise = -1; ck_rise = -1;
      cke_rise = -1; done_rise = -1; cke_early = 0;
      p_start = 0; p_rst = 0; p_ck = 0; p_cke = 0; p_done = 0;
    end else begin
      if (cs_n != '1 && ev_n < 32) begin
        ev_cyc[ev_n] = cyc; ev_cs[ev_n] = cs_n;
        ev_rcw[ev_n] = {ras_n, cas_n, we_n};
        ev_bank[ev_n] = bank; ev_addr[ev_n] = addr;
        ev_n++;
      end else if (cs_n != '1) ev_n++;
      if (p_start && !phy_init_start) start_fall = cyc;
      if (!p_rst && mem_reset_n) rst_rise = cyc;
      if (!p_ck && ck_en) ck_rise = cyc;
      if (!p_cke && cke) cke_rise = cyc;
      if (!p_done && done) done_rise = cyc;
      if (cke && !mem_reset_n) cke_early = 1;
      p_start = phy_init_start; p_rst = mem_reset_n; p_ck = ck_en;
      p_cke = cke; p_done = done;
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_case(input int rl, input int rc, input int cs, input int xpr,
                          input int mrd, input int mdd, input int phy_dly,
                          input logic [ROW_W-1:0] m0, input logic [ROW_W-1:0] m1,
                          input logic [ROW_W-1:0] m2, input logic [ROW_W-1:0] m3);
    int exp_c;
    int k;
    int guard;
    int phy_ok;
    logic [ROW_W-1:0] ea [7];
    logic [2:0] er [7];
    int eb [7];
    int eg [7];
    @(negedge clk);
    rst_n = 1'b0;
    t_rst_low = CNT_W'(rl); t_rst_to_cke = CNT_W'(rc); t_clk_stable = CNT_W'(cs);
    t_xpr = CNT_W'(xpr); t_mrd = CNT_W'(mrd); t_mod = CNT_W'(mdd);
    mr0_val = m0; mr1_val = m1; mr2_val = m2; mr3_val = m3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R10: reset state at the ports
    chk("R2 reset_n low after reset", int'(mem_reset_n), 0);
    chk("R2 cke low after reset", int'(cke), 0);
    chk("R10 bus deselected after reset", int'(cs_n), (1 << RANKS) - 1);
    chk("R9 done low after reset", int'(done), 0);
    chk("R1 phy start low in idle", int'(phy_init_start), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 phy start raised", int'(phy_init_start), 1);
    phy_ok = 1;
    for (int i = 0; i < phy_dly; i++) begin
      @(negedge clk);
      if (!phy_init_start) phy_ok = 0;
    end
    chk("R1 phy start held while waiting", phy_ok, 1);
    phy_init_done = 1'b1;
    @(negedge clk);
    phy_init_done = 1'b0;
    chk("R1 phy start dropped after done", int'(phy_init_start), 0);
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: done actual 0 expected 1");
    end
    repeat (20) @(negedge clk);
    chk("R2 reset_n rise delay", rst_rise - start_fall, eff(rl));
    chk("R3 clock starts with reset release", ck_rise, rst_rise);
    chk("R3 cke rise delay", cke_rise - rst_rise, (eff(rc) > eff(cs)) ? eff(rc) : eff(cs));
    chk("R3 cke never high under reset", cke_early, 0);
    chk("R10 command count", ev_n, NEV);
    er[0] = 3'b111; ea[0] = '0;                        eb[0] = 0; eg[0] = eff(xpr);
    er[1] = 3'b000; ea[1] = m2 & 16'hF9FF;             eb[1] = 2; eg[1] = eff(mrd);
    er[2] = 3'b000; ea[2] = m3;                        eb[2] = 3; eg[2] = eff(mrd);
    er[3] = 3'b000; ea[3] = m1 & 16'hFFFE;             eb[3] = 1; eg[3] = eff(mrd);
    er[4] = 3'b000; ea[4] = m0 | 16'h0100;             eb[4] = 0; eg[4] = eff(mrd);
    er[5] = 3'b000; ea[5] = m0 & 16'hFEFF;             eb[5] = 0; eg[5] = eff(mdd);
    er[6] = 3'b110; ea[6] = 16'h0400;                  eb[6] = 0; eg[6] = ZQ;
    exp_c = cke_rise + 1; // R5: first NOP one cycle after cke
    k = 0;
    if (ev_n == NEV) begin
      for (int r = 0; r < RANKS; r++) begin
        for (int j = 0; j < 7; j++) begin
          chk($sformatf("R5 R6 R8 timing rank %0d step %0d", r, j), ev_cyc[k], exp_c);
          chk($sformatf("R7 cs_n rank %0d step %0d", r, j), int'(ev_cs[k]),
              ((1 << RANKS) - 1) & ~(1 << r));
          chk($sformatf("R7 strobes rank %0d step %0d", r, j), int'(ev_rcw[k]), int'(er[j]));
          chk($sformatf("R6 bank rank %0d step %0d", r, j), int'(ev_bank[k]), eb[j]);
          chk($sformatf("R6 R8 addr rank %0d step %0d", r, j), int'(ev_addr[k]), int'(ea[j]));
          exp_c += eg[j];
          k++;
        end
      end
      chk("R9 precharge-all timing", ev_cyc[k], exp_c);
      chk("R9 precharge-all cs_n", int'(ev_cs[k]), 0);
      chk("R9 precharge-all strobes", int'(ev_rcw[k]), 3'b010);
      chk("R9 precharge-all A10", int'(ev_addr[k]), 16'h0400);
      chk("R9 done with precharge-all", done_rise, exp_c);
    end
    chk("R9 done stays high", int'(done), 1);
    chk("R10 bus idle after done", int'(cs_n), (1 << RANKS) - 1);
  endtask

  initial begin
    // R4: zero counts in the second case act as one
    run_case(7, 5, 9, 6, 4, 12, 3, 16'h1234, 16'h0045, 16'h0618, 16'h0004);
    run_case(0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    run_case(3, 40, 2, 25, 1, 1, 9, 16'h0000, 16'h0001, 16'h0200, 16'hA5A5);
    run_case(1, 2, 2, 1, 7, 3, 1, 16'h0D70, 16'h0044, 16'h0408, 16'h0000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule